// File: doc/BRIEF.md
# Dual Clock Output Selection Sequencer

This block is the digital control path in front of a two-channel clock synthesizer. It decides what drives the video clock pin and the memory clock pin. The candidate sources are the video synthesizer, the memory synthesizer, a reference clock, an external clock input and a power-down divisor clock. It decodes the static control pins and the three video register selects. When the selection changes, or when a live register is rewritten, it runs two timed phases. The first is a decision window, during which the output keeps its previous source. The second is a settling window, during which a substitute clock stands in while the synthesizer locks.

Every change of source goes through a break-before-make switch. The old source is stopped while it is low. The new source is passed only once it is also low. As a result, the pins only ever carry full high phases of a real source. All source clocks are brought into the control clock domain through two-flop synchronisers. Both windows are counted in control-clock cycles, and one configuration bit doubles both of them. The block tells the video synthesizer which register it should run from, and it sends each synthesizer a one-cycle strobe when a new setting is to be applied.

Top module: `dual_clksel`

## Requirements
- R1: While `oe` is 0, the next clock edge drives `vclk_oe`, `mclk_oe`, `vclk_out` and `mclk_out` to 0, whatever the other inputs are.
- R2: With `oe`=1, `pd_n`=0 and `pd_mode2`=0, `vclk_out` is 1 from the next edge on, and `mclk_out` carries the power-down divisor clock `pdiv_clk`.
- R3: With `pd_n`=0 and `pd_mode2`=1, both `vclk_oe` and `mclk_oe` are 0 from the next edge on, and both clock outputs are 0.
- R4: The register select code is `sel` = {SEL1, SEL0}. Code 00 selects register 0, code 01 selects register 1 and code 11 selects register 2. Code 10 with `ext_sel`=1 also selects register 2. The active register appears on `vsyn_reg` once the decision window ends.
- R5: Code 10 with `ext_sel`=0 routes `ext_clk` to `vclk_out` once both windows have passed. No `vsyn_load` strobe is issued for this selection.
- R6: `force_r2`=1 selects register 2 whatever the values of `sel` and `ext_sel`.
- R7: After the decoded selection changes, `vclk_out` keeps the old source for `TO_CYC` cycles. Any further change within that window restarts it. When the window ends, `vsyn_reg` updates and `vsyn_load` pulses once.
- R8: A settling window of `SET_CYC` cycles follows the decision window. During it, `vclk_out` carries `ref_clk` when `sub_mclk`=0 and the memory clock output when `sub_mclk`=1. After it, the new source is used.
- R9: A pulse on `vreg_wr[i]`, where i is the active register, puts `ref_clk` on `vclk_out` for the decision and settling windows and issues one `vsyn_load`. A write to an inactive register changes nothing at the outputs.
- R10: A pulse on `mreg_wr` puts `ref_clk` on `mclk_out` for the decision and settling windows. `msyn_load` pulses once, at the end of the decision window.
- R11: With `long_to`=1, both the decision window and the settling window last twice their parameter value.
- R12: Every high pulse on `vclk_out` or `mclk_out` is a complete high phase of one source. The old source is stopped low, and the new one is enabled only while it is low.
- R13: During reset, all outputs are 0 and `vsyn_reg` reports register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; counts both windows |
| rst | input | 1 | Synchronous reset, active high |
| oe | input | 1 | Output enable; 0 disables both clock pins |
| pd_n | input | 1 | Power-down request, active low |
| ext_sel | input | 1 | External clock select qualifier |
| force_r2 | input | 1 | Forces register 2 onto the video clock |
| sel | input | 2 | Register select code {SEL1, SEL0} |
| pd_mode2 | input | 1 | Power-down style: 0 divisor clock on memory pin, 1 all outputs off |
| sub_mclk | input | 1 | Settling substitute: 0 reference, 1 memory clock |
| long_to | input | 1 | Doubles both windows |
| vreg_wr | input | 3 | One-cycle rewrite strobes for video registers 0..2 |
| mreg_wr | input | 1 | One-cycle rewrite strobe for the memory register |
| ref_clk | input | 1 | Reference clock |
| ext_clk | input | 1 | External clock input |
| vsyn_clk | input | 1 | Video synthesizer output |
| msyn_clk | input | 1 | Memory synthesizer output |
| pdiv_clk | input | 1 | Power-down divisor clock |
| vclk_out | output | 1 | Video clock pin data |
| vclk_oe | output | 1 | Video clock pin drive enable |
| mclk_out | output | 1 | Memory clock pin data |
| mclk_oe | output | 1 | Memory clock pin drive enable |
| vsyn_reg | output | 2 | Register the video synthesizer runs from |
| vsyn_load | output | 1 | Apply-new-setting strobe to the video synthesizer |
| msyn_load | output | 1 | Apply-new-setting strobe to the memory synthesizer |

## Verification
A wrong phase or a wrong window count shows up within one source period, as a high-pulse width that belongs to another source. For example, the reference width appears where the synthesizer width was due, or the reverse. A stale current or pending choice shows up at the first cycle after the window boundary as a wrong `vsyn_reg` value or an extra or missing load strobe. A missed restart of the decision window moves that boundary by the restart offset. A fault in a break-before-make handshake leaves a high pulse shorter than any source half period, and that pulse appears at the output during the switch itself.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DECIDE = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  // Decoded video choice: external clock or a synthesizer register index
  typedef struct packed {
    logic       ext;
    logic [1:0] idx;
  } vchoice_t;

  localparam int NVREG = 3;

  // Video mux source order
  localparam logic [1:0] VS_SYN = 2'd0;
  localparam logic [1:0] VS_EXT = 2'd1;
  localparam logic [1:0] VS_REF = 2'd2;
  localparam logic [1:0] VS_MCK = 2'd3;

  // Memory mux source order
  localparam logic [1:0] MS_SYN = 2'd0;
  localparam logic [1:0] MS_REF = 2'd1;
  localparam logic [1:0] MS_PDV = 2'd2;

  function automatic vchoice_t decode_pins(input logic force_r2,
                                           input logic ext_sel,
                                           input logic [1:0] sel);
    vchoice_t c;
    c = '{ext: 1'b0, idx: 2'd2};
    if (!force_r2) begin
      case (sel)
        2'b00: c = '{ext: 1'b0, idx: 2'd0};
        2'b01: c = '{ext: 1'b0, idx: 2'd1};
        2'b10: c = ext_sel ? '{ext: 1'b0, idx: 2'd2} : '{ext: 1'b1, idx: 2'd0};
        default: c = '{ext: 1'b0, idx: 2'd2};
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import clksel_pkg::*;
#(
  parameter int TO_CYC  = 24,
  parameter int SET_CYC = 48
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   long_to,
  input  logic   restart,
  output phase_e phase,
  output logic   decide_done
);
  localparam int BIGGER = (TO_CYC > SET_CYC) ? TO_CYC : SET_CYC;
  localparam int CW     = $clog2(2 * BIGGER + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          last;

  always_comb begin
    if (phase == PH_SETTLE) lim = long_to ? CW'(2 * SET_CYC) : CW'(SET_CYC);
    else                    lim = long_to ? CW'(2 * TO_CYC)  : CW'(TO_CYC);
  end

  assign last        = (cnt == lim - ONE);
  assign decide_done = (phase == PH_DECIDE) && last && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (restart) begin
      phase <= PH_DECIDE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_DECIDE: begin
          cnt <= last ? '0 : cnt + ONE;
          if (last) phase <= PH_SETTLE;
        end
        PH_SETTLE: begin
          cnt <= last ? '0 : cnt + ONE;
          if (last) phase <= PH_IDLE;
        end
        default: cnt <= '0;
      endcase
    end
  end

  // R7 R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (cnt < lim));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase == PH_DECIDE));
endmodule

// File: rtl/vsel_ctrl.sv
module vsel_ctrl
  import clksel_pkg::*;
#(
  parameter int TO_CYC  = 24,
  parameter int SET_CYC = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             long_to,
  input  logic             sub_mclk,
  input  logic             force_r2,
  input  logic             ext_sel,
  input  logic [1:0]       sel,
  input  logic [NVREG-1:0] vreg_wr,
  output logic [1:0]       src,
  output logic [1:0]       reg_idx,
  output logic             load
);
  vchoice_t tgt, cur, pend, nxt_pend;
  logic     rw, nxt_rw, restart, done, act_wr;
  phase_e   ph;

  assign tgt    = decode_pins(force_r2, ext_sel, sel);
  assign act_wr = !cur.ext && vreg_wr[cur.idx];

  always_comb begin
    restart  = 1'b0;
    nxt_pend = pend;
    nxt_rw   = rw;
    if (ph == PH_DECIDE) begin
      if (tgt != pend) begin
        restart  = 1'b1;
        nxt_pend = tgt;
        nxt_rw   = 1'b0;
      end
    end else if (tgt != cur) begin
      restart  = 1'b1;
      nxt_pend = tgt;
      nxt_rw   = 1'b0;
    end else if (act_wr) begin
      restart  = 1'b1;
      nxt_pend = cur;
      nxt_rw   = 1'b1;
    end
  end

  phase_timer #(.TO_CYC(TO_CYC), .SET_CYC(SET_CYC)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .long_to    (long_to),
    .restart    (restart),
    .phase      (ph),
    .decide_done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      pend <= '0;
      rw   <= 1'b0;
      load <= 1'b0;
    end else begin
      pend <= nxt_pend;
      rw   <= nxt_rw;
      load <= done && !pend.ext;
      if (done) cur <= pend;
    end
  end

  always_comb begin
    case (ph)
      PH_SETTLE: src = sub_mclk ? VS_MCK : VS_REF;
      PH_DECIDE: src = rw ? VS_REF : (cur.ext ? VS_EXT : VS_SYN);
      default:   src = cur.ext ? VS_EXT : VS_SYN;
    endcase
  end

  assign reg_idx = cur.idx;

  // R7
  load_after_decide_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> ($past(ph) == PH_DECIDE));

  // R9
  wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && tgt == cur && vreg_wr != '0 && !act_wr) |=> (ph == PH_IDLE));
endmodule

// File: rtl/gf_mux.sv
module gf_mux #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  lvl,
  input  logic [IW-1:0] sel,
  output logic          out
);
  logic [IW-1:0] act;
  logic          on;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
      on  <= 1'b0;
      out <= 1'b0;
    end else begin
      out <= on && lvl[act];
      if (on) begin
        if (sel != act && !lvl[act]) on <= 1'b0;
      end else begin
        act <= sel;
        if (act == sel && !lvl[sel]) on <= 1'b1;
      end
    end
  end

  // R12
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(on) |-> !$past(lvl[act]));

  // R12
  make_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(on) |-> !$past(lvl[act]));
endmodule

// File: rtl/dual_clksel.sv
module dual_clksel
  import clksel_pkg::*;
#(
  parameter int TO_CYC  = 24,
  parameter int SET_CYC = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       oe,
  input  logic       pd_n,
  input  logic       ext_sel,
  input  logic       force_r2,
  input  logic [1:0] sel,
  input  logic       pd_mode2,
  input  logic       sub_mclk,
  input  logic       long_to,
  input  logic [2:0] vreg_wr,
  input  logic       mreg_wr,
  input  logic       ref_clk,
  input  logic       ext_clk,
  input  logic       vsyn_clk,
  input  logic       msyn_clk,
  input  logic       pdiv_clk,
  output logic       vclk_out,
  output logic       vclk_oe,
  output logic       mclk_out,
  output logic       mclk_oe,
  output logic [1:0] vsyn_reg,
  output logic       vsyn_load,
  output logic       msyn_load
);
  localparam int NSRC = 5;

  logic [NSRC-1:0] lv;
  phase_e          mph;
  logic            mdone, pd_act, en, mmux_out, vmux_out;
  logic [1:0]      msel, vsel;

  lvl_sync #(.W(NSRC)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({pdiv_clk, msyn_clk, vsyn_clk, ext_clk, ref_clk}),
    .q  (lv)
  );

  phase_timer #(.TO_CYC(TO_CYC), .SET_CYC(SET_CYC)) u_mtmr (
    .clk        (clk),
    .rst        (rst),
    .long_to    (long_to),
    .restart    (mreg_wr),
    .phase      (mph),
    .decide_done(mdone)
  );

  assign pd_act = !pd_n;

  always_comb begin
    if (pd_act && !pd_mode2)  msel = MS_PDV;
    else if (mph != PH_IDLE)  msel = MS_REF;
    else                      msel = MS_SYN;
  end

  gf_mux #(.N(3)) u_mmux (
    .clk(clk),
    .rst(rst),
    .lvl({lv[4], lv[0], lv[3]}),
    .sel(msel),
    .out(mmux_out)
  );

  vsel_ctrl #(.TO_CYC(TO_CYC), .SET_CYC(SET_CYC)) u_vctl (
    .clk     (clk),
    .rst     (rst),
    .long_to (long_to),
    .sub_mclk(sub_mclk),
    .force_r2(force_r2),
    .ext_sel (ext_sel),
    .sel     (sel),
    .vreg_wr (vreg_wr),
    .src     (vsel),
    .reg_idx (vsyn_reg),
    .load    (vsyn_load)
  );

  gf_mux #(.N(4)) u_vmux (
    .clk(clk),
    .rst(rst),
    .lvl({mmux_out, lv[0], lv[1], lv[2]}),
    .sel(vsel),
    .out(vmux_out)
  );

  assign en = oe && !(pd_act && pd_mode2);

  always_ff @(posedge clk) begin
    if (rst) begin
      vclk_oe   <= 1'b0;
      mclk_oe   <= 1'b0;
      vclk_out  <= 1'b0;
      mclk_out  <= 1'b0;
      msyn_load <= 1'b0;
    end else begin
      vclk_oe   <= en;
      mclk_oe   <= en;
      vclk_out  <= en && (pd_act || vmux_out);
      mclk_out  <= en && mmux_out;
      msyn_load <= mdone;
    end
  end

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |=> (!vclk_oe && !mclk_oe && !vclk_out && !mclk_out));

  // R2
  pd_high_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && !pd_n && !pd_mode2) |=> vclk_out);

  // R3
  pd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd_n && pd_mode2) |=> (!vclk_oe && !mclk_oe));

  // R10
  mem_restart_chk: assert property (@(posedge clk) disable iff (rst)
    mreg_wr |=> (mph == PH_DECIDE));
endmodule

// File: tb/dual_clksel_bench.sv
`timescale 1ns/1ps
module dual_clksel_bench;
  localparam int TO = 24, SET = 48;
  localparam int H_REF = 4, H_EXT = 5, H_VSYN = 3, H_MSYN = 2, H_PDIV = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, oe, pd_n, ext_sel, force_r2, pd_mode2, sub_mclk, long_to, mreg_wr;
  logic [1:0] sel;
  logic [2:0] vreg_wr;
  logic ref_clk = 0, ext_clk = 0, vsyn_clk = 0, msyn_clk = 0, pdiv_clk = 0;
  logic vclk_out, vclk_oe, mclk_out, mclk_oe, vsyn_load, msyn_load;
  logic [1:0] vsyn_reg;

  dual_clksel #(.TO_CYC(TO), .SET_CYC(SET)) u_dual_clksel (
    .clk(clk), .rst(rst), .oe(oe), .pd_n(pd_n), .ext_sel(ext_sel), .force_r2(force_r2),
    .sel(sel), .pd_mode2(pd_mode2), .sub_mclk(sub_mclk), .long_to(long_to),
    .vreg_wr(vreg_wr), .mreg_wr(mreg_wr), .ref_clk(ref_clk), .ext_clk(ext_clk),
    .vsyn_clk(vsyn_clk), .msyn_clk(msyn_clk), .pdiv_clk(pdiv_clk),
    .vclk_out(vclk_out), .vclk_oe(vclk_oe), .mclk_out(mclk_out), .mclk_oe(mclk_oe),
    .vsyn_reg(vsyn_reg), .vsyn_load(vsyn_load), .msyn_load(msyn_load));

  // source clocks toggle on the falling edge, away from the sampling edge
  int sc[5] = '{0, 0, 0, 0, 0};
  always @(negedge clk) begin
    sc[0]++; if (sc[0] == H_REF)  begin sc[0] = 0; ref_clk  <= ~ref_clk;  end
    sc[1]++; if (sc[1] == H_EXT)  begin sc[1] = 0; ext_clk  <= ~ext_clk;  end
    sc[2]++; if (sc[2] == H_VSYN) begin sc[2] = 0; vsyn_clk <= ~vsyn_clk; end
    sc[3]++; if (sc[3] == H_MSYN) begin sc[3] = 0; msyn_clk <= ~msyn_clk; end
    sc[4]++; if (sc[4] == H_PDIV) begin sc[4] = 0; pdiv_clk <= ~pdiv_clk; end
  end

  int cyc = 0;
  always @(posedge clk) cyc++;

  int nchk = 0, nfail = 0, vload_n = 0, mload_n = 0;
  bit gf_on = 0;

  typedef struct { int chan; int width; string tag; int t; } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: measures high-pulse widths on both pins and consumes expectations
  bit prev[2] = '{0, 0};
  int hcnt[2] = '{0, 0};
  int rise[2] = '{0, 0};
  always @(negedge clk) begin
    bit lvl[2];
    if (vsyn_load) vload_n++;
    if (msyn_load) mload_n++;
    lvl[0] = vclk_out;
    lvl[1] = mclk_out;
    for (int c = 0; c < 2; c++) begin
      if (lvl[c] && !prev[c]) begin rise[c] = cyc; hcnt[c] = 1; end
      else if (lvl[c]) hcnt[c]++;
      else if (prev[c]) begin
        if (gf_on) begin
          // R12: only whole source half periods may appear
          if (c == 0) chk(hcnt[c] inside {2, 3, 4, 5}, "R12 vclk pulse", hcnt[c], 3);
          else        chk(hcnt[c] inside {2, 4, 6}, "R12 mclk pulse", hcnt[c], 2);
        end
        if (q.size() > 0 && q[0].chan == c && rise[c] > q[0].t) begin
          chk(hcnt[c] == q[0].width, q[0].tag, hcnt[c], q[0].width);
          void'(q.pop_front());
        end
      end
      prev[c] = lvl[c];
    end
  end

  task automatic expect_pulse(int chan, int w, string tag);
    exp_t e;
    e.chan = chan; e.width = w; e.tag = tag; e.t = cyc;
    q.push_back(e);
    for (int i = 0; i < 80 && q.size() > 0; i++) @(negedge clk);
    if (q.size() > 0) begin
      chk(0, {tag, " no pulse"}, 0, w);
      q.delete();
    end
  endtask

  task automatic upto(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t0, t1, lv0, lm0;
    rst = 1; oe = 1; pd_n = 1; ext_sel = 1; force_r2 = 0; sel = 2'b00;
    pd_mode2 = 0; sub_mclk = 0; long_to = 0; vreg_wr = '0; mreg_wr = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(vclk_out == 0 && mclk_out == 0 && vclk_oe == 0 && mclk_oe == 0, "R13 pins", vclk_out, 0);
    chk(vsyn_reg == 0 && vsyn_load == 0 && msyn_load == 0, "R13 reg/strobes", vsyn_reg, 0);
    rst = 0;
    repeat (30) @(negedge clk);
    chk(vclk_oe == 1 && mclk_oe == 1, "R1 enables on", vclk_oe, 1);
    expect_pulse(0, H_VSYN, "R4 reg0 vsyn source");
    expect_pulse(1, H_MSYN, "R10 idle mem source");
    gf_on = 1;

    // R7 R8 R4: select register 1
    lv0 = vload_n; sel = 2'b01; t0 = cyc;
    upto(t0 + 1); expect_pulse(0, H_VSYN, "R7 old source kept");
    upto(t0 + TO - 1); chk(vsyn_reg == 0, "R7 reg before window end", vsyn_reg, 0);
    upto(t0 + TO + 2); chk(vsyn_reg == 1, "R4 code 01 reg1", vsyn_reg, 1);
    upto(t0 + TO + 3); chk(vload_n == lv0 + 1, "R7 one load strobe", vload_n - lv0, 1);
    upto(t0 + TO + 16); expect_pulse(0, H_REF, "R8 ref substitute");
    upto(t0 + TO + SET + 16); expect_pulse(0, H_VSYN, "R8 new source after settle");

    // R7 restart on a second change
    sel = 2'b11; t0 = cyc;
    upto(t0 + 10); sel = 2'b00;
    upto(t0 + TO + 2); chk(vsyn_reg == 1, "R7 window restarted", vsyn_reg, 1);
    upto(t0 + 10 + TO + 2); chk(vsyn_reg == 0, "R4 code 00 reg0", vsyn_reg, 0);
    upto(t0 + 10 + TO + SET + 10);

    // R11 doubled windows
    long_to = 1; sel = 2'b11; t0 = cyc;
    upto(t0 + TO + 2); chk(vsyn_reg == 0, "R11 decide doubled", vsyn_reg, 0);
    upto(t0 + 2*TO + 2); chk(vsyn_reg == 2, "R4 code 11 reg2", vsyn_reg, 2);
    upto(t0 + 2*TO + SET + 10); expect_pulse(0, H_REF, "R11 settle doubled");
    upto(t0 + 2*TO + 2*SET + 10); long_to = 0;

    // R8 memory clock as substitute
    sub_mclk = 1; sel = 2'b00; t0 = cyc;
    upto(t0 + TO + 16); expect_pulse(0, H_MSYN, "R8 mclk substitute");
    upto(t0 + TO + SET + 10); sub_mclk = 0;

    // R5 external clock
    lv0 = vload_n; ext_sel = 0; sel = 2'b10; t0 = cyc;
    upto(t0 + TO + SET + 16); expect_pulse(0, H_EXT, "R5 ext clock routed");
    chk(vload_n == lv0, "R5 no load for ext", vload_n - lv0, 0);
    ext_sel = 1; t0 = cyc;
    upto(t0 + TO + 2); chk(vsyn_reg == 2, "R4 code 10 ext_sel=1 reg2", vsyn_reg, 2);
    upto(t0 + TO + SET + 10);

    // R6 forced register 2
    lv0 = vload_n; force_r2 = 1; sel = 2'b01; t0 = cyc;
    upto(t0 + TO + 2); chk(vsyn_reg == 2, "R6 force holds reg2", vsyn_reg, 2);
    chk(vload_n == lv0, "R6 no reselect", vload_n - lv0, 0);
    force_r2 = 0; t1 = cyc;
    upto(t1 + TO + 2); chk(vsyn_reg == 1, "R6 release to reg1", vsyn_reg, 1);
    upto(t1 + TO + SET + 10);

    // R9 rewrites: inactive then active
    lv0 = vload_n; vreg_wr = 3'b001; @(negedge clk); vreg_wr = '0; t0 = cyc;
    upto(t0 + 2); expect_pulse(0, H_VSYN, "R9 inactive write ignored");
    upto(t0 + TO + 3); chk(vload_n == lv0, "R9 inactive no load", vload_n - lv0, 0);
    vreg_wr = 3'b010; @(negedge clk); vreg_wr = '0; t1 = cyc;
    upto(t1 + 13); expect_pulse(0, H_REF, "R9 ref during rewrite");
    upto(t1 + TO + 3); chk(vload_n == lv0 + 1, "R9 rewrite load", vload_n - lv0, 1);
    chk(vsyn_reg == 1, "R9 reg unchanged", vsyn_reg, 1);
    upto(t1 + TO + SET + 10);

    // R10 memory register rewrite
    lm0 = mload_n; mreg_wr = 1; @(negedge clk); mreg_wr = 0; t0 = cyc;
    upto(t0 + 11); expect_pulse(1, H_REF, "R10 ref on mclk");
    upto(t0 + TO - 2); chk(mload_n == lm0, "R10 no early load", mload_n - lm0, 0);
    upto(t0 + TO + 3); chk(mload_n == lm0 + 1, "R10 one load", mload_n - lm0, 1);
    upto(t0 + TO + SET + 12); expect_pulse(1, H_MSYN, "R10 mem synth back");
    gf_on = 0;

    // R2 power-down, divisor mode
    pd_n = 0; t0 = cyc;
    upto(t0 + 2); chk(vclk_out == 1, "R2 vclk held high", vclk_out, 1);
    upto(t0 + 9); chk(vclk_out == 1 && vclk_oe == 1, "R2 vclk still high", vclk_out, 1);
    upto(t0 + 20); expect_pulse(1, H_PDIV, "R2 mclk from divisor");
    pd_n = 1; repeat (25) @(negedge clk);

    // R3 power-down, all off
    pd_mode2 = 1; pd_n = 0; repeat (2) @(negedge clk);
    chk(vclk_oe == 0 && mclk_oe == 0, "R3 enables off", vclk_oe, 0);
    chk(vclk_out == 0 && mclk_out == 0, "R3 pins low", vclk_out, 0);
    pd_n = 1; pd_mode2 = 0; repeat (10) @(negedge clk);

    // R1 output enable low
    oe = 0; repeat (2) @(negedge clk);
    chk(!vclk_oe && !mclk_oe && !vclk_out && !mclk_out, "R1 disabled", vclk_oe, 0);
    repeat (10) @(negedge clk);
    chk(!vclk_oe && !mclk_oe && !vclk_out && !mclk_out, "R1 stays disabled", mclk_oe, 0);
    oe = 1; repeat (2) @(negedge clk);
    chk(vclk_oe == 1 && mclk_oe == 1, "R1 re-enabled", mclk_oe, 1);

    finish_run();
  end
endmodule